// File: doc/BRIEF.md
# Line Activation Reset State Controller

This block supervises the link state of a two-wire digital line transceiver. It tracks five states: full reset, receive reset, starting, active and deactivating. It moves between them using a few status flags from the transceiver: received signal present, frame sync achieved, local transmitter sending and far-end activation tone heard. It also reads a start/stop control bit. Every supervision interval is counted in ticks of a 1 ms timebase input, so a fast tick shortens all intervals in proportion.

Full reset is the resting state after power-up. Local activation starts from full reset when the start/stop bit is set. If the received signal is lost while the local transmitter is silent, the block enters receive reset. Receive reset is a short waiting state: the block never starts activation on its own there, but it still answers an incoming activation tone. Clearing the start/stop bit in the active state begins deactivation. Deactivation is capped in time. Once it ends, a later activation proceeds from full reset as a warm start.

Each timed state restarts its timer on every entry. Failures of start-up, loss of signal, loss of sync and deactivation overrun each leave a sticky flag for the controlling logic.

Top module: `line_act_ctrl`

## Requirements
- R1: After reset the state output is 0 (full reset), and the start-up request and all four flags are 0.
- R2: In full reset with start/stop at 1, the block enters starting (code 2). The start-up request is 1 for exactly the first cycle in starting. In full reset with start/stop at 0 and the tone flag high, the block enters starting without raising the request.
- R3: In receive reset (code 1), the start/stop bit has no effect and the start-up request stays 0. A high tone flag moves the block to starting, still with no request.
- R4: Receive reset returns to full reset on the RXR_MS-th tick counted after entry.
- R5: Starting moves to active (code 3) when frame sync is high. After STARTUP_MS ticks in starting without sync, the block returns to full reset and sets the start-up failure flag, which stays set until reset.
- R6: In active, a loss counter counts ticks while the received signal is low and clears whenever the signal is high. When it reaches LOS_MS, the loss-of-signal flag is set (sticky). The block then goes to receive reset if the transmitter flag is low, or to full reset if it is high.
- R7: In active, a second counter counts ticks while frame sync is low and clears whenever sync is high. When it reaches LSYNC_MS, the loss-of-sync flag is set (sticky) and the block goes to full reset. If both losses complete on the same tick, only the signal loss is acted on.
- R8: In active, start/stop at 0 moves the block to deactivating (code 4), taking priority over both loss counters. In deactivating, a low received signal ends deactivation and the block goes to full reset.
- R9: If deactivating lasts DEACT_MS ticks with the received signal still present, the block goes to full reset and sets the deactivation-overrun flag (sticky).
- R10: After a completed deactivation, setting start/stop to 1 starts a new activation from full reset, with the start-up request as in R2.
- R11: State codes are 0 full reset, 1 receive reset, 2 starting, 3 active, 4 deactivating. Every timer starts from zero on entry to its state and advances only on cycles where the tick input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, asynchronous assert, active low |
| tick_ms | input | 1 | One-cycle timebase tick, nominally once per millisecond |
| start_bit | input | 1 | Start/stop control: 1 requests activation, 0 requests deactivation |
| rx_sig | input | 1 | Received line signal present |
| tx_active | input | 1 | Local transmitter is sending |
| frm_sync | input | 1 | Frame synchronisation achieved |
| tone_det | input | 1 | Far-end activation tone detected |
| state_o | output | 3 | Current state code (see R11) |
| startup_req | output | 1 | Pulse: locally initiated start-up sequence begins |
| los_flag | output | 1 | Sticky: loss of received signal declared |
| lsync_flag | output | 1 | Sticky: loss of frame sync declared |
| startup_fail | output | 1 | Sticky: start-up did not complete in time |
| deact_tmo | output | 1 | Sticky: deactivation exceeded its time cap |

## Verification
The bench builds the block with RXR_MS=4, STARTUP_MS=20, LOS_MS=6, LSYNC_MS=8 and DEACT_MS=10. With these values every supervision timeout ends within a few dozen cycles, so each expiry path can be driven to completion several times. The tick input runs at gaps of one, two and three cycles, which tests that timers advance only on ticks and restart on each state entry. Partial signal losses that recover before the limit, and the warm-restart loop after deactivation, are also within reach at these sizes.

// File: rtl/line_act_pkg.sv
package line_act_pkg;

  typedef enum logic [2:0] {
    ST_FULL_RST = 3'd0,
    ST_RX_RST   = 3'd1,
    ST_STARTING = 3'd2,
    ST_ACTIVE   = 3'd3,
    ST_DEACT    = 3'd4
  } lac_state_e;

  typedef struct packed {
    logic req;
    logic fail;
    logic los;
    logic lsync;
    logic dto;
  } lac_evt_t;

  function automatic int lac_max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lac_tick_timer.sv
module lac_tick_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expire = run && tick && (cnt_q == limit - CW'(1));
  assign cnt_en = clr || (run && tick && (cnt_q != limit));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run && tick && (cnt_q != limit)) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R11: the count never runs past the limit it is timing against
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R11: the count only moves on a tick or a restart
  p_cnt_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/lac_next_state.sv
module lac_next_state
  import line_act_pkg::*;
(
  input  lac_state_e state_q,
  input  logic       start_bit,
  input  logic       tone_det,
  input  logic       tx_active,
  input  logic       rx_sig,
  input  logic       st_exp,
  input  logic       los_exp,
  input  logic       lsy_exp,
  input  logic       frm_sync,
  output lac_state_e state_d,
  output lac_evt_t   evt
);

  always_comb begin
    state_d = state_q;
    evt     = '0;
    case (state_q)
      ST_FULL_RST: begin
        if (start_bit) begin
          state_d = ST_STARTING;
          evt.req = 1'b1;
        end else if (tone_det) begin
          state_d = ST_STARTING;
        end
      end
      ST_RX_RST: begin
        if (tone_det) begin
          state_d = ST_STARTING;
        end else if (st_exp) begin
          state_d = ST_FULL_RST;
        end
      end
      ST_STARTING: begin
        if (frm_sync) begin
          state_d = ST_ACTIVE;
        end else if (st_exp) begin
          state_d  = ST_FULL_RST;
          evt.fail = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (!start_bit) begin
          state_d = ST_DEACT;
        end else if (los_exp) begin
          evt.los = 1'b1;
          state_d = tx_active ? ST_FULL_RST : ST_RX_RST;
        end else if (lsy_exp) begin
          evt.lsync = 1'b1;
          state_d   = ST_FULL_RST;
        end
      end
      ST_DEACT: begin
        if (!rx_sig) begin
          state_d = ST_FULL_RST;
        end else if (st_exp) begin
          state_d = ST_FULL_RST;
          evt.dto = 1'b1;
        end
      end
      default: state_d = ST_FULL_RST;
    endcase
  end

endmodule

// File: rtl/line_act_ctrl.sv
module line_act_ctrl
  import line_act_pkg::*;
#(
  parameter int RXR_MS     = 40,
  parameter int STARTUP_MS = 15000,
  parameter int LOS_MS     = 480,
  parameter int LSYNC_MS   = 480,
  parameter int DEACT_MS   = 520
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       start_bit,
  input  logic       rx_sig,
  input  logic       tx_active,
  input  logic       frm_sync,
  input  logic       tone_det,
  output logic [2:0] state_o,
  output logic       startup_req,
  output logic       los_flag,
  output logic       lsync_flag,
  output logic       startup_fail,
  output logic       deact_tmo
);

  localparam int MAX_MS = lac_max2(lac_max2(lac_max2(RXR_MS, STARTUP_MS),
                                            lac_max2(LOS_MS, LSYNC_MS)), DEACT_MS);
  localparam int CW     = $clog2(MAX_MS + 1);
  localparam int NLOSS  = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  lac_state_e    state_q, state_d;
  lac_evt_t      evt;
  logic          st_timed, st_exp, st_chg;
  logic [CW-1:0] st_limit;
  logic [NLOSS-1:0] loss_ok, loss_exp;
  logic [CW-1:0]    loss_lim [NLOSS];
  logic          req_q;
  logic          los_q, lsync_q, fail_q, dto_q;

  // state supervision timer limit per state
  always_comb begin
    st_timed = 1'b1;
    case (state_q)
      ST_RX_RST:   st_limit = CW'(RXR_MS);
      ST_STARTING: st_limit = CW'(STARTUP_MS);
      ST_DEACT:    st_limit = CW'(DEACT_MS);
      default: begin
        st_limit = CW'(1);
        st_timed = 1'b0;
      end
    endcase
  end

  assign st_chg = (state_d != state_q);

  lac_tick_timer #(.CW(CW)) u_st_tmr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (st_chg),
    .run    (st_timed),
    .tick   (tick_ms),
    .limit  (st_limit),
    .expire (st_exp)
  );

  // loss supervisors in the active state: [0] received signal, [1] frame sync
  assign loss_ok     = {frm_sync, rx_sig};
  assign loss_lim[0] = CW'(LOS_MS);
  assign loss_lim[1] = CW'(LSYNC_MS);

  for (genvar g = 0; g < NLOSS; g++) begin : g_loss
    lac_tick_timer #(.CW(CW)) u_loss_tmr (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .clr    ((state_q != ST_ACTIVE) || loss_ok[g]),
      .run    ((state_q == ST_ACTIVE) && !loss_ok[g]),
      .tick   (tick_ms),
      .limit  (loss_lim[g]),
      .expire (loss_exp[g])
    );
  end

  lac_next_state u_nxt (
    .state_q   (state_q),
    .start_bit (start_bit),
    .tone_det  (tone_det),
    .tx_active (tx_active),
    .rx_sig    (rx_sig),
    .st_exp    (st_exp),
    .los_exp   (loss_exp[0]),
    .lsy_exp   (loss_exp[1]),
    .frm_sync  (frm_sync),
    .state_d   (state_d),
    .evt       (evt)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_FULL_RST;
      req_q   <= 1'b0;
      los_q   <= 1'b0;
      lsync_q <= 1'b0;
      fail_q  <= 1'b0;
      dto_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= evt.req;
      if (evt.los)   los_q   <= 1'b1;
      if (evt.lsync) lsync_q <= 1'b1;
      if (evt.fail)  fail_q  <= 1'b1;
      if (evt.dto)   dto_q   <= 1'b1;
    end
  end

  assign state_o      = state_q;
  assign startup_req  = req_q;
  assign los_flag     = los_q;
  assign lsync_flag   = lsync_q;
  assign startup_fail = fail_q;
  assign deact_tmo    = dto_q;

  // R2: a request pulse only appears on first entry to starting from full reset
  p_req_from_full_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_q |-> (state_q == ST_STARTING) && ($past(state_q) == ST_FULL_RST));

  // R3: leaving receive reset never raises the start-up request
  p_rxrst_no_req_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_RX_RST) |=> !req_q);

  // R5: failure flag is sticky
  p_fail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    fail_q |=> fail_q);

  // R6: loss-of-signal flag rises only when leaving active to a reset state
  p_los_exit_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(los_q) |-> ($past(state_q) == ST_ACTIVE) &&
                     (state_q == ST_RX_RST || state_q == ST_FULL_RST));

  // R8: deactivating exits only to full reset
  p_deact_exit_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_DEACT) |=> (state_q == ST_DEACT || state_q == ST_FULL_RST));

  // R11: state code stays within the defined set
  p_code_legal_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    state_q <= ST_DEACT);

endmodule

// File: tb/line_act_ctrl_tb.sv
module line_act_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P_RXR      = 4;
  localparam int P_STARTUP  = 20;
  localparam int P_LOS      = 6;
  localparam int P_LSYNC    = 8;
  localparam int P_DEACT    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic start_bit = 1'b0, rx_sig = 1'b0, tx_active = 1'b0;
  logic frm_sync = 1'b0, tone_det = 1'b0;
  logic [2:0] state_o;
  logic startup_req, los_flag, lsync_flag, startup_fail, deact_tmo;

  int checks = 0;
  int errors = 0;
  int tick_gap = 1;
  int tick_ph = 0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  line_act_ctrl #(
    .RXR_MS(P_RXR), .STARTUP_MS(P_STARTUP), .LOS_MS(P_LOS),
    .LSYNC_MS(P_LSYNC), .DEACT_MS(P_DEACT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .start_bit(start_bit),
    .rx_sig(rx_sig), .tx_active(tx_active), .frm_sync(frm_sync),
    .tone_det(tone_det), .state_o(state_o), .startup_req(startup_req),
    .los_flag(los_flag), .lsync_flag(lsync_flag),
    .startup_fail(startup_fail), .deact_tmo(deact_tmo)
  );

  // tick generator
  always @(negedge clk) begin
    tick_ph = tick_ph + 1;
    tick_ms = (tick_gap <= 1) ? 1'b1 : ((tick_ph % tick_gap) == 0);
  end

  // behavioural reference model
  int m_st = 0, m_tmr = 0, m_los = 0, m_lsy = 0;
  bit m_req = 0, m_flos = 0, m_flsy = 0, m_fail = 0, m_dto = 0;

  always @(posedge clk) begin
    int nxt, lim;
    bit sexp, lexp, yexp;
    if (!rst_n) begin
      m_st = 0; m_tmr = 0; m_los = 0; m_lsy = 0;
      m_req = 0; m_flos = 0; m_flsy = 0; m_fail = 0; m_dto = 0;
    end else begin
      lim = (m_st == 1) ? P_RXR : (m_st == 2) ? P_STARTUP : (m_st == 4) ? P_DEACT : 0;
      sexp = tick_ms && lim > 0 && m_tmr == lim - 1;
      lexp = tick_ms && !rx_sig && m_los == P_LOS - 1;
      yexp = tick_ms && !frm_sync && m_lsy == P_LSYNC - 1;
      nxt = m_st;
      m_req = 0;
      case (m_st)
        0: if (start_bit) begin nxt = 2; m_req = 1; end
           else if (tone_det) nxt = 2;
        1: if (tone_det) nxt = 2; else if (sexp) nxt = 0;
        2: if (frm_sync) nxt = 3; else if (sexp) begin nxt = 0; m_fail = 1; end
        3: if (!start_bit) nxt = 4;
           else if (lexp) begin m_flos = 1; nxt = tx_active ? 0 : 1; end
           else if (yexp) begin m_flsy = 1; nxt = 0; end
        4: if (!rx_sig) nxt = 0; else if (sexp) begin nxt = 0; m_dto = 1; end
        default: nxt = 0;
      endcase
      if (m_st != 3 || rx_sig) m_los = 0; else if (tick_ms) m_los = m_los + 1;
      if (m_st != 3 || frm_sync) m_lsy = 0; else if (tick_ms) m_lsy = m_lsy + 1;
      if (nxt != m_st) m_tmr = 0; else if (tick_ms && lim > 0) m_tmr = m_tmr + 1;
      m_st = nxt;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (state_o !== 3'(m_st) || startup_req !== m_req || los_flag !== m_flos ||
          lsync_flag !== m_flsy || startup_fail !== m_fail || deact_tmo !== m_dto) begin
        errors++;
        $display("FAIL %s: actual st=%0d req=%0b los=%0b lsy=%0b fail=%0b dto=%0b expected st=%0d req=%0b los=%0b lsy=%0b fail=%0b dto=%0b",
                 phase, state_o, startup_req, los_flag, lsync_flag, startup_fail, deact_tmo,
                 m_st, m_req, m_flos, m_flsy, m_fail, m_dto);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_state(input int code, input int maxc, input string tag);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      #1;
      if (state_o == 3'(code)) return;
    end
    chk(tag, int'(state_o), code);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(4);
    rst_n = 1'b1;
    cycles(5);
    phase = "R1 reset state";
    chk("R1 state", int'(state_o), 0);
    chk("R1 flags", int'({startup_req, los_flag, lsync_flag, startup_fail, deact_tmo}), 0);

    phase = "R2 local start";
    rx_sig = 1'b1; start_bit = 1'b1;
    wait_state(2, 10, "R2 enter starting");
    chk("R2 request pulse", int'(startup_req), 1);
    cycles(1);
    chk("R2 request one cycle", int'(startup_req), 0);

    phase = "R5 sync to active";
    frm_sync = 1'b1;
    wait_state(3, 10, "R5 active");
    chk("R11 active code", int'(state_o), 3);

    phase = "R6 partial loss recovers";
    tick_gap = 2;
    rx_sig = 1'b0; cycles(4); rx_sig = 1'b1; cycles(1);
    rx_sig = 1'b0; cycles(4); rx_sig = 1'b1; cycles(1);
    chk("R6 counter clears", int'(state_o), 3);
    phase = "R6 loss to receive reset";
    rx_sig = 1'b0; tx_active = 1'b0;
    wait_state(1, 60, "R6 receive reset");
    chk("R6 loss flag", int'(los_flag), 1);

    phase = "R3 start bit ignored";
    cycles(2);
    chk("R3 stays in receive reset", int'(state_o), 1);
    chk("R3 no request", int'(startup_req), 0);
    tone_det = 1'b1;
    wait_state(2, 5, "R3 tone answer");
    tone_det = 1'b0;
    chk("R3 no request on tone", int'(startup_req), 0);
    rx_sig = 1'b1;
    wait_state(3, 10, "R3 back to active");

    phase = "R4 receive reset timeout";
    tick_gap = 1;
    rx_sig = 1'b0;
    wait_state(1, 40, "R4 enter receive reset");
    start_bit = 1'b0;
    cycles(1);
    wait_state(0, 20, "R4 timeout to full reset");
    cycles(3);
    chk("R4 stays full", int'(state_o), 0);

    phase = "R5 start-up timeout";
    tick_gap = 3;
    rx_sig = 1'b1; frm_sync = 1'b0; start_bit = 1'b1;
    wait_state(2, 10, "R5 starting");
    wait_state(0, 100, "R5 timeout");
    chk("R5 fail flag", int'(startup_fail), 1);
    frm_sync = 1'b1;
    wait_state(3, 10, "R5 active again");

    phase = "R7 loss of sync";
    tick_gap = 2;
    tx_active = 1'b1; frm_sync = 1'b0;
    wait_state(0, 60, "R7 full reset");
    chk("R7 lsync flag", int'(lsync_flag), 1);
    frm_sync = 1'b1;
    wait_state(3, 10, "R7 active again");

    phase = "R6 loss while transmitting";
    rx_sig = 1'b0;
    wait_state(0, 60, "R6 full reset with tx");
    rx_sig = 1'b1;
    wait_state(3, 10, "R6 active again");

    phase = "R8 deactivation";
    tick_gap = 1;
    start_bit = 1'b0;
    wait_state(4, 5, "R8 deactivating");
    cycles(2);
    rx_sig = 1'b0;
    wait_state(0, 5, "R8 completes");
    chk("R8 no overrun", int'(deact_tmo), 0);

    phase = "R10 warm start";
    rx_sig = 1'b1; start_bit = 1'b1;
    wait_state(2, 5, "R10 restart");
    chk("R10 request", int'(startup_req), 1);
    wait_state(3, 5, "R10 active");

    phase = "R9 deactivation overrun";
    tick_gap = 2;
    start_bit = 1'b0;
    wait_state(4, 5, "R9 deactivating");
    wait_state(0, 40, "R9 overrun exit");
    chk("R9 overrun flag", int'(deact_tmo), 1);

    phase = "R2 tone from full reset";
    cycles(2);
    tone_det = 1'b1;
    wait_state(2, 5, "R2 tone start");
    chk("R2 no request on tone", int'(startup_req), 0);
    tone_det = 1'b0;
    wait_state(3, 5, "R2 active by tone");
    cycles(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule